// File: doc/BRIEF.md
# Buck Converter Start-up and Fault Supervisor

This block sequences start-up and protection for a synchronous buck controller. It takes digital results from analog comparators as inputs: supply lockout, soft-start progress, output window, over-voltage, under-voltage and die temperature. From these it decides whether the converter runs. It drives four things: a run/shutdown signal, a reset that holds the soft-start capacitor discharged, a pull-down request for the open-drain power-good pin, and a request that forces the low-side switch on during over-voltage. It also reports whether a fault is latched.

The comparators for the output window, over-voltage and under-voltage can chatter, so each passes through its own deglitch counter. A flag takes a new level only after it has held that level for `FILT_CYC` consecutive clocks. At 50 MHz the default of 100 clocks gives 2 µs. Over-voltage does not latch: it clamps the output through the low-side switch while it lasts. Under-voltage latches the converter off, but only after soft start has finished. An over-temperature event shuts the converter down. Recovery then passes through the reset state, so a complete soft start follows.

The state machine has five states:
- `ST_OFF`: disabled or in lockout.
- `ST_SOFTSTART`: ramping.
- `ST_RUN`: soft start complete.
- `ST_THERMAL`: over-temperature shutdown.
- `ST_LATCHED`: under-voltage fault latched.

Its transitions, in priority order:
- Any state except `ST_OFF` goes to `ST_OFF` when enable or supply is lost (internal reset).
- `ST_OFF` goes to `ST_SOFTSTART` when enable and supply are both good.
- `ST_SOFTSTART` or `ST_RUN` goes to `ST_THERMAL` on over-temperature.
- `ST_SOFTSTART` goes to `ST_RUN` when soft start is complete.
- `ST_RUN` goes to `ST_LATCHED` on a filtered under-voltage.
- `ST_THERMAL` goes to `ST_OFF` once the temperature recovers.

Top module: `buck_fault_supervisor`

## Requirements
- R1: After reset, `run_o`=0, `ss_rst_o`=1, `pg_pull_o`=1, `ls_force_o`=0 and `fault_latched_o`=0. Leaving `ST_OFF` requires `en_i`=1 and `uvlo_ok_i`=1; `run_o` then rises and `ss_rst_o` falls one clock later.
- R2: From any running, thermal or latched state, `en_i`=0 or `uvlo_ok_i`=0 returns the block to `ST_OFF` on the next clock. In `ST_OFF`, `run_o`=0, `ss_rst_o`=1 and `fault_latched_o`=0.
- R3: `pg_pull_o`=0 (power good released) only in `ST_RUN` with `pg_lvl_i`=1 and both filtered window flags low. `light_load_ok_o`=1 only in `ST_RUN` with `pg_lvl_i`=1.
- R4: A filtered `win_hi_i` or `win_lo_i` (output outside ±10%) drives `pg_pull_o`=1.
- R5: While running, a filtered `ovp_i` sets `ls_force_o`=1 without stopping `run_o`. `ls_force_o` returns to 0 when the filtered flag clears, and no fault is latched.
- R6: A filtered `uvp_i` in `ST_RUN` moves to `ST_LATCHED` on the next clock. In `ST_SOFTSTART` (before `ss_done_i`=1) `uvp_i` has no effect.
- R7: In `ST_LATCHED`, `fault_latched_o`=1, `run_o`=0, `ss_rst_o`=1 and `pg_pull_o`=1. This persists after `uvp_i` clears, until `en_i` or `uvlo_ok_i` goes low.
- R8: `otp_i`=1 in `ST_SOFTSTART` or `ST_RUN` stops the converter on the next clock. When `otp_i` clears, one clock of `ST_OFF` (soft-start reset held) precedes a new `ST_SOFTSTART`.
- R9: A window, over-voltage or under-voltage flag changes its filtered level only after holding the new level for `FILT_CYC` consecutive clocks. A pulse of `FILT_CYC`-1 clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| uvlo_ok_i | input | 1 | Supply above lockout threshold |
| ss_done_i | input | 1 | Soft-start reached reference level |
| pg_lvl_i | input | 1 | Soft-start reached power-good enable level |
| win_hi_i | input | 1 | Output above +10% window (raw) |
| win_lo_i | input | 1 | Output below −10% window (raw) |
| ovp_i | input | 1 | Output above 120% (raw) |
| uvp_i | input | 1 | Output below 75% (raw) |
| otp_i | input | 1 | Die over-temperature |
| run_o | output | 1 | Converter run (1) / shutdown (0) |
| ss_rst_o | output | 1 | Hold soft-start capacitor discharged |
| pg_pull_o | output | 1 | Pull power-good pin low |
| ls_force_o | output | 1 | Force low-side switch on |
| light_load_ok_o | output | 1 | Light-load mode permitted |
| fault_latched_o | output | 1 | Under-voltage fault latched |

## Verification
A wrong state register shows at `run_o`, `ss_rst_o` and `fault_latched_o` one clock after the input that should have moved it. For example, a missed latch leaves `run_o` high, and a missed thermal pass-through shows `run_o` rising without the reset clock between. A faulty deglitch counter appears `FILT_CYC` clocks after the raw flag changes: the response is early, late or missing at `pg_pull_o`, `ls_force_o` or the latch. A flag that is wrongly unmasked during soft start appears as a latch while `ss_done_i` is still low.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_SOFTSTART,
        ST_RUN,
        ST_THERMAL,
        ST_LATCHED
    } sup_state_t;

    localparam int FLG_WHI = 0;
    localparam int FLG_WLO = 1;
    localparam int FLG_OV  = 2;
    localparam int FLG_UV  = 3;
    localparam int NUM_FLG = 4;
endpackage

// File: rtl/sup_deglitch.sv
module sup_deglitch #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            flt_o <= 1'b0;
        end else if (raw_i != flt_o) begin
            if (cnt == CW'(CYC - 1)) begin
                flt_o <= raw_i;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    // R9: counter never reaches the full window without flipping
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(CYC));
    // R9: filtered level only moves toward what the raw input showed
    assert_flip_follows_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_o != $past(flt_o)) |-> ($past(raw_i) == flt_o));
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic uvlo_ok_i,
    input  logic ss_done_i,
    input  logic pg_lvl_i,
    input  logic otp_i,
    input  logic whi_f,
    input  logic wlo_f,
    input  logic ov_f,
    input  logic uv_f,
    output logic run_o,
    output logic ss_rst_o,
    output logic pg_pull_o,
    output logic ls_force_o,
    output logic light_load_ok_o,
    output logic fault_latched_o
);
    sup_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (en_i && uvlo_ok_i) state_nx = ST_SOFTSTART;
            end
            ST_SOFTSTART: begin
                if (!en_i || !uvlo_ok_i) state_nx = ST_OFF;
                else if (otp_i)          state_nx = ST_THERMAL;
                else if (ss_done_i)      state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!en_i || !uvlo_ok_i) state_nx = ST_OFF;
                else if (otp_i)          state_nx = ST_THERMAL;
                else if (uv_f)           state_nx = ST_LATCHED;
            end
            ST_THERMAL: begin
                if (!en_i || !uvlo_ok_i || !otp_i) state_nx = ST_OFF;
            end
            ST_LATCHED: begin
                if (!en_i || !uvlo_ok_i) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        run_o           = 1'b0;
        ss_rst_o        = 1'b1;
        pg_pull_o       = 1'b1;
        ls_force_o      = 1'b0;
        light_load_ok_o = 1'b0;
        fault_latched_o = 1'b0;
        unique case (state)
            ST_OFF, ST_THERMAL: ;
            ST_SOFTSTART: begin
                run_o      = 1'b1;
                ss_rst_o   = 1'b0;
                ls_force_o = ov_f;
            end
            ST_RUN: begin
                run_o           = 1'b1;
                ss_rst_o        = 1'b0;
                ls_force_o      = ov_f;
                light_load_ok_o = pg_lvl_i;
                pg_pull_o       = !(pg_lvl_i && !whi_f && !wlo_f);
            end
            ST_LATCHED: fault_latched_o = 1'b1;
            default: ;
        endcase
    end

    // R1: running only follows a cycle with enable and supply good
    assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> $past(en_i && uvlo_ok_i));
    // R3: power good released only while running with level reached, no latch
    assert_pg_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_o |-> (run_o && pg_lvl_i && !fault_latched_o));
    // R6: latch entered only from running state on a filtered under-voltage
    assert_latch_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched_o) |-> ($past(uv_f) && $past(run_o)));
    // R7: latch clears only through enable or supply loss
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched_o) |-> $past(!en_i || !uvlo_ok_i));
    // R8: thermal exit never resumes running directly
    assert_thermal_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_THERMAL && state != ST_THERMAL) |-> !run_o);
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
    import sup_pkg::*;
#(
    parameter int FILT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic uvlo_ok_i,
    input  logic ss_done_i,
    input  logic pg_lvl_i,
    input  logic win_hi_i,
    input  logic win_lo_i,
    input  logic ovp_i,
    input  logic uvp_i,
    input  logic otp_i,
    output logic run_o,
    output logic ss_rst_o,
    output logic pg_pull_o,
    output logic ls_force_o,
    output logic light_load_ok_o,
    output logic fault_latched_o
);
    logic [NUM_FLG-1:0] raw_flags, flt_flags;

    always_comb begin
        raw_flags          = '0;
        raw_flags[FLG_WHI] = win_hi_i;
        raw_flags[FLG_WLO] = win_lo_i;
        raw_flags[FLG_OV]  = ovp_i;
        raw_flags[FLG_UV]  = uvp_i;
    end

    for (genvar g = 0; g < NUM_FLG; g++) begin : g_filt
        sup_deglitch #(.CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[g]),
            .flt_o (flt_flags[g])
        );
    end

    sup_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (en_i),
        .uvlo_ok_i       (uvlo_ok_i),
        .ss_done_i       (ss_done_i),
        .pg_lvl_i        (pg_lvl_i),
        .otp_i           (otp_i),
        .whi_f           (flt_flags[FLG_WHI]),
        .wlo_f           (flt_flags[FLG_WLO]),
        .ov_f            (flt_flags[FLG_OV]),
        .uv_f            (flt_flags[FLG_UV]),
        .run_o           (run_o),
        .ss_rst_o        (ss_rst_o),
        .pg_pull_o       (pg_pull_o),
        .ls_force_o      (ls_force_o),
        .light_load_ok_o (light_load_ok_o),
        .fault_latched_o (fault_latched_o)
    );
endmodule

// File: tb/tb_buck_fault_supervisor.sv
`timescale 1ns/1ps
module tb_buck_fault_supervisor;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 0, uvlo_ok_i = 0, ss_done_i = 0, pg_lvl_i = 0;
    logic win_hi_i = 0, win_lo_i = 0, ovp_i = 0, uvp_i = 0, otp_i = 0;
    logic run_o, ss_rst_o, pg_pull_o, ls_force_o, light_load_ok_o, fault_latched_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    buck_fault_supervisor #(.FILT_CYC(N)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_ok_i(uvlo_ok_i),
        .ss_done_i(ss_done_i), .pg_lvl_i(pg_lvl_i), .win_hi_i(win_hi_i),
        .win_lo_i(win_lo_i), .ovp_i(ovp_i), .uvp_i(uvp_i), .otp_i(otp_i),
        .run_o(run_o), .ss_rst_o(ss_rst_o), .pg_pull_o(pg_pull_o),
        .ls_force_o(ls_force_o), .light_load_ok_o(light_load_ok_o),
        .fault_latched_o(fault_latched_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset run_o", run_o, 1'b0);
        chk("R1 reset ss_rst_o", ss_rst_o, 1'b1);
        chk("R1 reset pg_pull_o", pg_pull_o, 1'b1);
        chk("R1 reset ls_force_o", ls_force_o, 1'b0);
        chk("R1 reset fault_latched_o", fault_latched_o, 1'b0);
    endtask

    task automatic t_start();
        uvlo_ok_i = 1; en_i = 0; step(3);
        chk("R1 no start without enable", run_o, 1'b0);
        en_i = 0; uvlo_ok_i = 0; step(1);
        en_i = 1; step(3);
        chk("R1 no start in lockout", run_o, 1'b0);
        uvlo_ok_i = 1; step(1);
        chk("R1 run after enable+supply", run_o, 1'b1);
        chk("R1 soft-start reset released", ss_rst_o, 1'b0);
    endtask

    task automatic t_pgood();
        chk("R3 pulldown in soft start", pg_pull_o, 1'b1);
        ss_done_i = 1; step(1);
        chk("R3 pulldown before pg level", pg_pull_o, 1'b1);
        chk("R3 light load blocked before pg level", light_load_ok_o, 1'b0);
        pg_lvl_i = 1; step(1);
        chk("R3 pg released", pg_pull_o, 1'b0);
        chk("R3 light load allowed", light_load_ok_o, 1'b1);
    endtask

    task automatic t_window();
        win_lo_i = 1; step(N + 1);
        chk("R4 low window pulls pg", pg_pull_o, 1'b1);
        win_lo_i = 0; step(N + 1);
        chk("R4 low window cleared", pg_pull_o, 1'b0);
        win_hi_i = 1; step(N + 1);
        chk("R4 high window pulls pg", pg_pull_o, 1'b1);
        win_hi_i = 0; step(N + 1);
        chk("R4 high window cleared", pg_pull_o, 1'b0);
    endtask

    task automatic t_ovp();
        ovp_i = 1; step(N + 1);
        chk("R5 low side forced", ls_force_o, 1'b1);
        chk("R5 still running", run_o, 1'b1);
        ovp_i = 0; step(N + 1);
        chk("R5 low side released", ls_force_o, 1'b0);
        chk("R5 no latch", fault_latched_o, 1'b0);
    endtask

    task automatic t_glitch();
        uvp_i = 1; step(N - 1);
        uvp_i = 0; step(N + 2);
        chk("R9 short pulse ignored (latch)", fault_latched_o, 1'b0);
        chk("R9 short pulse ignored (run)", run_o, 1'b1);
        ovp_i = 1; step(N - 1);
        chk("R9 short ovp not forced", ls_force_o, 1'b0);
        ovp_i = 0; step(N + 2);
    endtask

    task automatic t_uv_masked();
        en_i = 0; step(1);
        chk("R2 enable low stops", run_o, 1'b0);
        chk("R2 enable low holds ss reset", ss_rst_o, 1'b1);
        ss_done_i = 0; en_i = 1; step(1);
        uvp_i = 1; step(N + 3);
        chk("R6 uv masked in soft start", fault_latched_o, 1'b0);
        chk("R6 running in soft start", run_o, 1'b1);
        uvp_i = 0; step(N + 2);
    endtask

    task automatic t_uv_latch();
        ss_done_i = 1; step(1);
        uvp_i = 1; step(N + 1);
        chk("R6 uv latches", fault_latched_o, 1'b1);
        chk("R7 latched stops run", run_o, 1'b0);
        chk("R7 latched pulls pg", pg_pull_o, 1'b1);
        chk("R7 latched holds ss reset", ss_rst_o, 1'b1);
        uvp_i = 0; step(N + 2);
        chk("R7 latch persists", fault_latched_o, 1'b1);
        en_i = 0; step(1);
        chk("R7 enable toggle clears", fault_latched_o, 1'b0);
        en_i = 1; step(1);
        chk("R7 restart after toggle", run_o, 1'b1);
        step(1);
        uvp_i = 1; step(N + 1);
        chk("R6 relatch", fault_latched_o, 1'b1);
        uvp_i = 0; step(N + 2);
        uvlo_ok_i = 0; step(1);
        chk("R2 supply drop clears latch", fault_latched_o, 1'b0);
        chk("R2 supply drop run", run_o, 1'b0);
        uvlo_ok_i = 1; step(1);
        chk("R2 restart after supply", run_o, 1'b1);
        step(1);
    endtask

    task automatic t_otp();
        otp_i = 1; step(1);
        chk("R8 otp stops", run_o, 1'b0);
        chk("R8 otp ss reset", ss_rst_o, 1'b1);
        step(5);
        chk("R8 stays off while hot", run_o, 1'b0);
        otp_i = 0; step(1);
        chk("R8 reset clock after recovery", ss_rst_o, 1'b1);
        chk("R8 not running yet", run_o, 1'b0);
        step(1);
        chk("R8 fresh soft start", run_o, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1; step(1);
        t_start();
        t_pgood();
        t_window();
        t_ovp();
        t_glitch();
        t_uv_masked();
        t_uv_latch();
        t_otp();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule